// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block arbitrates atomic read-modify-write sequences for several processor cores. A core opens a reservation with a load-exclusive. It later tries to commit with a store-exclusive, and the block answers in the same cycle with a one-bit status: 0 lets the write go ahead, 1 refuses it. Software loops until it reads 0. The memory datapath, the bus and coherence are not part of this block.

Each core has two reservations:
- A private one, held in the core-local monitor.
- One slot in a shared table that covers shareable memory.

The following events drop the private reservation:
- a store-exclusive, whatever its outcome;
- a clear-exclusive, which issues no memory traffic and so replaces a dummy store-exclusive;
- an exception entry or return pulse.

The shared slot is dropped when another core writes the reserved word. It is also dropped by the owner's own shareable store-exclusive.

The monitor cannot tell which software thread made a reservation. An operating system must therefore issue a clear-exclusive on every thread switch. Without it, a reservation left by one thread can let another thread's store-exclusive succeed when it should fail.

Top module: `excl_monitor`

## Requirements
- R1: After reset no core holds any reservation, so a store-exclusive from any core returns status 1.
- R2: A load-exclusive records the word granule (address bits above bit 1) in the core's private reservation. A non-shareable store-exclusive to the same granule, with any value of bits 1:0, returns status 0. A store-exclusive to another granule returns status 1.
- R3: Every store-exclusive removes the issuing core's private reservation, whether it succeeds or fails. A shareable one also removes the core's shared slot.
- R4: A clear-exclusive removes only the private reservation, so the next store-exclusive fails. The core's shared slot is left untouched.
- R5: An exception pulse removes the private reservation. If it arrives with a load-exclusive from the same core, the load-exclusive is ignored. If it arrives with a store-exclusive, that store fails.
- R6: A shareable store-exclusive succeeds only when both the private reservation and the shared slot are valid and match its granule. A non-shareable store-exclusive needs only the private reservation.
- R7: An ordinary store, or a successful shareable store-exclusive, by one core clears the shared slot of every other core whose slot matches that granule. A failed store-exclusive clears no other core's slot.
- R8: When several cores issue shareable store-exclusives to the same granule in one cycle and each would otherwise succeed, only the lowest-numbered core gets status 0.
- R9: Consider a reservation left by one thread: load-exclusive, switch, load-exclusive, store-exclusive, load-exclusive, switch, store-exclusive. The final store-exclusive succeeds unless a clear-exclusive is issued at each switch, and fails when it is.
- R10: The status is valid in the same cycle as the store-exclusive strobe. It reads 0 on any core that issues no store-exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ldx_vld | input | NUM_CORES | Load-exclusive strobe, one bit per core |
| ldx_addr | input | NUM_CORES x ADDR_W | Load-exclusive address per core |
| stx_vld | input | NUM_CORES | Store-exclusive strobe per core |
| stx_addr | input | NUM_CORES x ADDR_W | Store-exclusive address per core |
| stx_shr | input | NUM_CORES | Store-exclusive targets shareable memory |
| clrx_vld | input | NUM_CORES | Clear-exclusive strobe per core |
| st_vld | input | NUM_CORES | Ordinary store strobe per core |
| st_addr | input | NUM_CORES x ADDR_W | Ordinary store address per core |
| exc_pulse | input | NUM_CORES | Exception entry or return pulse per core |
| stx_fail | output | NUM_CORES | Store-exclusive status: 1 means refused |

## Verification
The assertions assume that each core raises at most one of load-exclusive, store-exclusive, clear-exclusive and ordinary store in a cycle. An exception pulse may coincide with any of them. Under that assumption, the properties about tag removal and about an untouched shared slot hold without exceptions. The random stimulus picks a single operation per core per cycle from a small pool of granules, so collisions between cores are frequent. It adds exception pulses independently, and the directed cases keep to the same rule.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  // Action applied to one core's private reservation in a cycle
  typedef enum logic [1:0] {
    RSV_HOLD = 2'd0,
    RSV_SET  = 2'd1,
    RSV_DROP = 2'd2
  } rsv_act_e;

  // Granule width for an address width: the two byte-select bits are ignored
  function automatic int gran_w(input int addr_w);
    return addr_w - 2;
  endfunction

endpackage

// File: rtl/excl_rst_sync.sv
module excl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;

endmodule

// File: rtl/excl_local_mon.sv
module excl_local_mon
  import excl_mon_pkg::*;
#(
  parameter int GW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc,
  input  logic          ldx,
  input  logic [GW-1:0] ldx_gran,
  input  logic          stx,
  input  logic          clrx,
  output logic          rsv_vld,
  output logic [GW-1:0] rsv_gran
);

  rsv_act_e      act;
  logic          vld_d;
  logic [GW-1:0] gran_d;
  logic          gran_en;

  // Exception beats everything; store-exclusive and clear both drop
  always_comb begin
    act = RSV_HOLD;
    if (exc)
      act = RSV_DROP;
    else if (ldx)
      act = RSV_SET;
    else if (stx || clrx)
      act = RSV_DROP;
  end

  always_comb begin
    vld_d   = rsv_vld;
    gran_en = 1'b0;
    unique case (act)
      RSV_SET:  begin vld_d = 1'b1; gran_en = 1'b1; end
      RSV_DROP: vld_d = 1'b0;
      default:  vld_d = rsv_vld;
    endcase
    gran_d = ldx_gran;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rsv_vld <= 1'b0;
    else
      rsv_vld <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rsv_gran <= '0;
    else if (gran_en)
      rsv_gran <= gran_d;
  end

endmodule

// File: rtl/excl_stx_arb.sv
module excl_stx_arb #(
  parameter int NC = 4,
  parameter int GW = 30
) (
  input  logic [NC-1:0]         stx_vld,
  input  logic [NC-1:0]         stx_shr,
  input  logic [NC-1:0][GW-1:0] stx_gran,
  input  logic [NC-1:0]         exc,
  input  logic [NC-1:0]         lcl_vld,
  input  logic [NC-1:0][GW-1:0] lcl_gran,
  input  logic [NC-1:0]         glb_vld,
  input  logic [NC-1:0][GW-1:0] glb_gran,
  output logic [NC-1:0]         stx_ok
);

  logic [NC-1:0] cand;
  logic [NC-1:0] blocked;

  for (genvar i = 0; i < NC; i++) begin : g_cand
    logic lcl_hit;
    logic glb_hit;
    assign lcl_hit = lcl_vld[i] && (lcl_gran[i] == stx_gran[i]);
    assign glb_hit = glb_vld[i] && (glb_gran[i] == stx_gran[i]);
    assign cand[i] = stx_vld[i] && !exc[i] && lcl_hit && (!stx_shr[i] || glb_hit);
  end

  // Fixed priority: a lower index with a shareable store to the same granule wins
  for (genvar i = 0; i < NC; i++) begin : g_blk
    if (i == 0) begin : g_first
      assign blocked[i] = 1'b0;
    end else begin : g_rest
      logic [i-1:0] lower_hit;
      for (genvar j = 0; j < i; j++) begin : g_lo
        assign lower_hit[j] = cand[j] && stx_shr[j] && stx_shr[i] &&
                              (stx_gran[j] == stx_gran[i]);
      end
      assign blocked[i] = |lower_hit;
    end
  end

  assign stx_ok = cand & ~blocked;

endmodule

// File: rtl/excl_global_mon.sv
module excl_global_mon #(
  parameter int NC = 4,
  parameter int GW = 30
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NC-1:0]         ldx_acc,
  input  logic [NC-1:0][GW-1:0] ldx_gran,
  input  logic [NC-1:0]         stx_vld,
  input  logic [NC-1:0]         stx_shr,
  input  logic [NC-1:0][GW-1:0] stx_gran,
  input  logic [NC-1:0]         stx_ok,
  input  logic [NC-1:0]         st_vld,
  input  logic [NC-1:0][GW-1:0] st_gran,
  output logic [NC-1:0]         slot_vld,
  output logic [NC-1:0][GW-1:0] slot_gran
);

  logic [NC-1:0] snoop_hit;
  logic [NC-1:0] vld_d;

  for (genvar k = 0; k < NC; k++) begin : g_slot
    logic [NC-1:0] hit_from;
    for (genvar j = 0; j < NC; j++) begin : g_src
      if (j == k) begin : g_self
        assign hit_from[j] = 1'b0;
      end else begin : g_other
        logic st_hit;
        logic stx_hit;
        assign st_hit  = st_vld[j] && (st_gran[j] == slot_gran[k]);
        assign stx_hit = stx_ok[j] && stx_shr[j] && (stx_gran[j] == slot_gran[k]);
        assign hit_from[j] = st_hit || stx_hit;
      end
    end
    assign snoop_hit[k] = slot_vld[k] && (|hit_from);

    // Own load-exclusive sets; own shareable store-exclusive or a snoop clears
    always_comb begin
      if (ldx_acc[k])
        vld_d[k] = 1'b1;
      else if (stx_vld[k] && stx_shr[k])
        vld_d[k] = 1'b0;
      else if (snoop_hit[k])
        vld_d[k] = 1'b0;
      else
        vld_d[k] = slot_vld[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_vld[k] <= 1'b0;
      else
        slot_vld[k] <= vld_d[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_gran[k] <= '0;
      else if (ldx_acc[k])
        slot_gran[k] <= ldx_gran[k];
    end
  end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_CORES-1:0]              ldx_vld,
  input  logic [NUM_CORES-1:0][ADDR_W-1:0]  ldx_addr,
  input  logic [NUM_CORES-1:0]              stx_vld,
  input  logic [NUM_CORES-1:0][ADDR_W-1:0]  stx_addr,
  input  logic [NUM_CORES-1:0]              stx_shr,
  input  logic [NUM_CORES-1:0]              clrx_vld,
  input  logic [NUM_CORES-1:0]              st_vld,
  input  logic [NUM_CORES-1:0][ADDR_W-1:0]  st_addr,
  input  logic [NUM_CORES-1:0]              exc_pulse,
  output logic [NUM_CORES-1:0]              stx_fail
);

  localparam int GW = gran_w(ADDR_W);

  logic                          rst_n_int;
  logic [NUM_CORES-1:0][GW-1:0]  ldx_gran;
  logic [NUM_CORES-1:0][GW-1:0]  stx_gran;
  logic [NUM_CORES-1:0][GW-1:0]  st_gran;
  logic [NUM_CORES-1:0]          lcl_vld;
  logic [NUM_CORES-1:0][GW-1:0]  lcl_gran;
  logic [NUM_CORES-1:0]          glb_vld;
  logic [NUM_CORES-1:0][GW-1:0]  glb_gran;
  logic [NUM_CORES-1:0]          ldx_acc;
  logic [NUM_CORES-1:0]          stx_ok;
  logic [NUM_CORES-1:0][5:0]     unused_lo;

  excl_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign ldx_gran[c]  = ldx_addr[c][ADDR_W-1:2];
    assign stx_gran[c]  = stx_addr[c][ADDR_W-1:2];
    assign st_gran[c]   = st_addr[c][ADDR_W-1:2];
    assign unused_lo[c] = {ldx_addr[c][1:0], stx_addr[c][1:0], st_addr[c][1:0]};
    assign ldx_acc[c]   = ldx_vld[c] && !exc_pulse[c];

    excl_local_mon #(.GW(GW)) u_lcl (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .exc      (exc_pulse[c]),
      .ldx      (ldx_vld[c]),
      .ldx_gran (ldx_gran[c]),
      .stx      (stx_vld[c]),
      .clrx     (clrx_vld[c]),
      .rsv_vld  (lcl_vld[c]),
      .rsv_gran (lcl_gran[c])
    );
  end

  excl_stx_arb #(.NC(NUM_CORES), .GW(GW)) u_arb (
    .stx_vld  (stx_vld),
    .stx_shr  (stx_shr),
    .stx_gran (stx_gran),
    .exc      (exc_pulse),
    .lcl_vld  (lcl_vld),
    .lcl_gran (lcl_gran),
    .glb_vld  (glb_vld),
    .glb_gran (glb_gran),
    .stx_ok   (stx_ok)
  );

  excl_global_mon #(.NC(NUM_CORES), .GW(GW)) u_glb (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .ldx_acc   (ldx_acc),
    .ldx_gran  (ldx_gran),
    .stx_vld   (stx_vld),
    .stx_shr   (stx_shr),
    .stx_gran  (stx_gran),
    .stx_ok    (stx_ok),
    .st_vld    (st_vld),
    .st_gran   (st_gran),
    .slot_vld  (glb_vld),
    .slot_gran (glb_gran)
  );

  assign stx_fail = stx_vld & ~stx_ok;

endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 32
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_CORES-1:0]             ldx_vld,
  input logic [NUM_CORES-1:0]             stx_vld,
  input logic [NUM_CORES-1:0][ADDR_W-1:0] stx_addr,
  input logic [NUM_CORES-1:0]             stx_shr,
  input logic [NUM_CORES-1:0]             clrx_vld,
  input logic [NUM_CORES-1:0]             st_vld,
  input logic [NUM_CORES-1:0]             exc_pulse,
  input logic [NUM_CORES-1:0]             stx_fail,
  input logic [NUM_CORES-1:0]             lcl_vld,
  input logic [NUM_CORES-1:0]             glb_vld
);

  logic [NUM_CORES-1:0][1:0] unused_chk_lo;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_c
    assign unused_chk_lo[i] = stx_addr[i][1:0];

    // R3
    stx_drops_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stx_vld[i] |=> !lcl_vld[i]);

    // R3
    shr_stx_drops_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stx_vld[i] && stx_shr[i] && !ldx_vld[i]) |=> !glb_vld[i]);

    // R5
    exc_drops_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_pulse[i] |=> !lcl_vld[i]);

    // R4
    clrx_keeps_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clrx_vld[i] && !ldx_vld[i] && !stx_vld[i] && !(|st_vld) && !(|stx_vld))
        |=> $stable(glb_vld[i]));

    // R2
    no_rsv_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stx_vld[i] && !lcl_vld[i]) |-> stx_fail[i]);

    // R10
    idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stx_vld[i] |-> !stx_fail[i]);

    for (genvar j = i + 1; j < NUM_CORES; j++) begin : g_pair
      // R8
      single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stx_vld[i] && stx_vld[j] && stx_shr[i] && stx_shr[j] &&
          (stx_addr[i][ADDR_W-1:2] == stx_addr[j][ADDR_W-1:2]) &&
          !stx_fail[i] && !stx_fail[j]));
    end
  end

endmodule

bind excl_monitor excl_monitor_chk #(
  .NUM_CORES (NUM_CORES),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ldx_vld   (ldx_vld),
  .stx_vld   (stx_vld),
  .stx_addr  (stx_addr),
  .stx_shr   (stx_shr),
  .clrx_vld  (clrx_vld),
  .st_vld    (st_vld),
  .exc_pulse (exc_pulse),
  .stx_fail  (stx_fail),
  .lcl_vld   (lcl_vld),
  .glb_vld   (glb_vld)
);

// File: tb/excl_monitor_bench.sv
`timescale 1ns/1ps
module excl_monitor_bench;

  localparam int NC = 4;
  localparam int AW = 32;
  localparam int GW = AW - 2;

  logic                 clk;
  logic                 rst_n;
  logic [NC-1:0]        ldx_vld;
  logic [NC-1:0][AW-1:0] ldx_addr;
  logic [NC-1:0]        stx_vld;
  logic [NC-1:0][AW-1:0] stx_addr;
  logic [NC-1:0]        stx_shr;
  logic [NC-1:0]        clrx_vld;
  logic [NC-1:0]        st_vld;
  logic [NC-1:0][AW-1:0] st_addr;
  logic [NC-1:0]        exc_pulse;
  logic [NC-1:0]        stx_fail;

  int n_tests;
  int n_fail;

  // Bench reservation model
  logic          m_lv [NC];
  logic [GW-1:0] m_lg [NC];
  logic          m_gv [NC];
  logic [GW-1:0] m_gg [NC];

  excl_monitor #(.NUM_CORES(NC), .ADDR_W(AW)) u_excl_monitor (
    .clk(clk), .rst_n(rst_n),
    .ldx_vld(ldx_vld), .ldx_addr(ldx_addr),
    .stx_vld(stx_vld), .stx_addr(stx_addr), .stx_shr(stx_shr),
    .clrx_vld(clrx_vld), .st_vld(st_vld), .st_addr(st_addr),
    .exc_pulse(exc_pulse), .stx_fail(stx_fail)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [GW-1:0] gr(input logic [AW-1:0] a);
    return a[AW-1:2];
  endfunction

  task automatic idle();
    ldx_vld = '0; stx_vld = '0; stx_shr = '0; clrx_vld = '0;
    st_vld = '0; exc_pulse = '0;
    ldx_addr = '0; stx_addr = '0; st_addr = '0;
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      m_lv[c] = 1'b0; m_lg[c] = '0; m_gv[c] = 1'b0; m_gg[c] = '0;
    end
  endtask

  // Inputs are already driven (after a falling edge); check, then advance the model
  task automatic step(input string req);
    logic          cand [NC];
    logic          okv  [NC];
    logic          nlv  [NC];
    logic          ngv  [NC];
    logic [GW-1:0] nlg  [NC];
    logic [GW-1:0] ngg  [NC];
    #1;
    for (int c = 0; c < NC; c++) begin
      cand[c] = stx_vld[c] && !exc_pulse[c] && m_lv[c] && (m_lg[c] == gr(stx_addr[c])) &&
                (!stx_shr[c] || (m_gv[c] && m_gg[c] == gr(stx_addr[c])));
    end
    for (int c = 0; c < NC; c++) begin
      okv[c] = cand[c];
      for (int j = 0; j < c; j++)
        if (cand[j] && stx_shr[j] && stx_shr[c] && gr(stx_addr[j]) == gr(stx_addr[c]))
          okv[c] = 1'b0;
    end
    for (int c = 0; c < NC; c++) begin
      logic exp_f;
      exp_f = stx_vld[c] && !okv[c];
      n_tests++;
      if (stx_fail[c] !== exp_f) begin
        n_fail++;
        $display("FAIL %s R10 core %0d stx_fail actual %b expected %b at %0t",
                 req, c, stx_fail[c], exp_f, $time);
      end
    end
    for (int c = 0; c < NC; c++) begin
      logic snoop;
      nlv[c] = m_lv[c]; nlg[c] = m_lg[c]; ngv[c] = m_gv[c]; ngg[c] = m_gg[c];
      if (exc_pulse[c]) nlv[c] = 1'b0;
      else if (ldx_vld[c]) begin nlv[c] = 1'b1; nlg[c] = gr(ldx_addr[c]); end
      else if (stx_vld[c] || clrx_vld[c]) nlv[c] = 1'b0;
      snoop = 1'b0;
      for (int j = 0; j < NC; j++)
        if (j != c && ((st_vld[j] && gr(st_addr[j]) == m_gg[c]) ||
                       (okv[j] && stx_shr[j] && gr(stx_addr[j]) == m_gg[c])))
          snoop = 1'b1;
      if (ldx_vld[c] && !exc_pulse[c]) begin ngv[c] = 1'b1; ngg[c] = gr(ldx_addr[c]); end
      else if (stx_vld[c] && stx_shr[c]) ngv[c] = 1'b0;
      else if (snoop) ngv[c] = 1'b0;
    end
    for (int c = 0; c < NC; c++) begin
      m_lv[c] = nlv[c]; m_lg[c] = nlg[c]; m_gv[c] = ngv[c]; m_gg[c] = ngg[c];
    end
    @(negedge clk);
    idle();
  endtask

  // Directed single-operation helpers, one cycle each
  task automatic d_ldx(input int c, input logic [AW-1:0] a, input string req);
    ldx_vld[c] = 1'b1; ldx_addr[c] = a; step(req);
  endtask
  task automatic d_stx(input int c, input logic [AW-1:0] a, input logic s, input string req);
    stx_vld[c] = 1'b1; stx_addr[c] = a; stx_shr[c] = s; step(req);
  endtask
  task automatic d_clr(input int c, input string req);
    clrx_vld[c] = 1'b1; step(req);
  endtask
  task automatic d_st(input int c, input logic [AW-1:0] a, input string req);
    st_vld[c] = 1'b1; st_addr[c] = a; step(req);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired: actual hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  localparam logic [AW-1:0] A = 32'h0000_1000;
  localparam logic [AW-1:0] B = 32'h0000_1004;

  initial begin
    void'($urandom(32'd2024));
    n_tests = 0; n_fail = 0;
    idle();
    model_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: every core fails straight after reset
    for (int c = 0; c < NC; c++) begin stx_vld[c] = 1'b1; stx_addr[c] = A; stx_shr[c] = c[0]; end
    step("R1");

    // R2: granule match ignores bits 1:0; other granule fails
    d_ldx(0, A, "R2"); d_stx(0, A + 3, 1'b0, "R2");
    d_ldx(0, A, "R2"); d_stx(0, B, 1'b0, "R2");

    // R3: second store-exclusive fails after a success
    d_ldx(1, A, "R3"); d_stx(1, A, 1'b0, "R3"); d_stx(1, A, 1'b0, "R3");

    // R4: clear makes next store-exclusive fail
    d_ldx(2, A, "R4"); d_clr(2, "R4"); d_stx(2, A, 1'b0, "R4");

    // R5: exception alone, exception with ldx, exception with stx
    d_ldx(0, A, "R5"); exc_pulse[0] = 1'b1; step("R5"); d_stx(0, A, 1'b0, "R5");
    exc_pulse[0] = 1'b1; d_ldx(0, A, "R5"); d_stx(0, A, 1'b0, "R5");
    d_ldx(0, A, "R5"); exc_pulse[0] = 1'b1; d_stx(0, A, 1'b0, "R5");

    // R6: another core's store breaks shareable only
    d_ldx(0, A, "R6"); d_st(1, A + 2, "R6"); d_stx(0, A, 1'b1, "R6");
    d_ldx(0, A, "R6"); d_st(1, A, "R6"); d_stx(0, A, 1'b0, "R6");

    // R7: winning shareable stx clears others; failing one does not
    ldx_vld[0] = 1'b1; ldx_addr[0] = A; ldx_vld[1] = 1'b1; ldx_addr[1] = A; step("R7");
    d_stx(1, A, 1'b1, "R7"); d_stx(0, A, 1'b1, "R7");
    ldx_vld[0] = 1'b1; ldx_addr[0] = A; ldx_vld[1] = 1'b1; ldx_addr[1] = B; step("R7");
    d_stx(1, A, 1'b1, "R7"); d_stx(0, A, 1'b1, "R7");

    // R8: simultaneous shareable stores, lowest index wins
    for (int c = 0; c < NC; c++) begin ldx_vld[c] = 1'b1; ldx_addr[c] = A; end
    step("R8");
    for (int c = 0; c < NC; c++) begin stx_vld[c] = 1'b1; stx_addr[c] = A; stx_shr[c] = 1'b1; end
    step("R8");
    for (int c = 1; c < NC; c++) begin ldx_vld[c] = 1'b1; ldx_addr[c] = B; end
    step("R8");
    for (int c = 1; c < NC; c++) begin stx_vld[c] = 1'b1; stx_addr[c] = B; stx_shr[c] = 1'b1; end
    step("R8");

    // R9: stale reservation across a thread switch, without and with clear
    d_ldx(3, A, "R9"); d_ldx(3, A, "R9"); d_stx(3, A, 1'b0, "R9");
    d_ldx(3, A, "R9"); d_stx(3, A, 1'b0, "R9");
    d_ldx(3, A, "R9"); d_clr(3, "R9"); d_ldx(3, A, "R9"); d_stx(3, A, 1'b0, "R9");
    d_ldx(3, A, "R9"); d_clr(3, "R9"); d_stx(3, A, 1'b0, "R9");

    // Random traffic, one operation per core per cycle
    for (int n = 0; n < 4000; n++) begin
      for (int c = 0; c < NC; c++) begin
        int op;
        logic [AW-1:0] a;
        op = int'($urandom % 8);
        a  = A + AW'(($urandom % 4) * 4) + AW'($urandom % 4);
        case (op)
          0, 1: begin ldx_vld[c] = 1'b1; ldx_addr[c] = a; end
          2, 3: begin stx_vld[c] = 1'b1; stx_addr[c] = a; stx_shr[c] = 1'($urandom % 2); end
          4:    clrx_vld[c] = 1'b1;
          5:    begin st_vld[c] = 1'b1; st_addr[c] = a; end
          default: ;
        endcase
        exc_pulse[c] = (($urandom % 16) == 0);
      end
      step("R2,R6,R7");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule